// File: doc/BRIEF.md
# Phase-shifted full-bridge gate sequencer

This block produces the four gate commands of a full H-bridge that is regulated by phase shift rather than by pulse width. Leg A changes state on every strobe from the oscillator. Leg B changes state when the power cycle is ended, either by a phase-comparator trip or by a current-limit strobe. Both outputs of a leg are always low for a programmed number of cycles before the complementary output is allowed to rise. The selected output of each leg alternates from one period to the next, so the two diagonals of the bridge take turns carrying power.

A flag marks the window in which the present power cycle can still be ended. The window opens at each oscillator strobe and closes at the first terminating strobe. Any trip or limit strobe that arrives while the window is closed is ignored. A level inhibit input forces every gate low at once and freezes the sequence. After inhibit is released, the sequence waits for the next oscillator strobe before it starts again.

Top module: `psfb_gate_seq`

## Requirements
- R1: After reset all four gates and the flag are low, and they stay low until the first oscillator strobe that arrives while inhibit is low.
- R2: An oscillator strobe sampled at edge e turns the leg-A gate that was on off right after edge e. The other leg-A gate rises right after edge e+D, where D is dead_cnt_i sampled at edge e.
- R3: A terminating strobe sampled at edge e while the flag is high turns the leg-B gate that was on off right after edge e. The other leg-B gate rises right after edge e+D.
- R4: The first period after a start drives A1 together with B2. Each leg then changes its selected output once per period, so the next power diagonal is A2 with B1, then A1 with B2 again, and so on.
- R5: The two gates of one leg are never high together. Between one gate falling and the other rising there are exactly D cycles with both gates low.
- R6: A current-limit strobe ends the power cycle exactly as a phase trip does.
- R7: The flag rises one cycle after an oscillator strobe and falls one cycle after the first trip or limit strobe. Trip and limit strobes seen while the flag is low have no effect on any output.
- R8: If no terminating strobe arrives during a period, leg B changes its selected output at the next oscillator strobe, together with leg A. A trip in the same cycle as an oscillator strobe does not end the new power cycle.
- R9: While inhibit is high, all four gates are low in the same cycle, the flag clears at the next edge, and oscillator, trip and limit strobes are ignored.
- R10: After inhibit falls, no gate rises before the next oscillator strobe. The restart then follows R2, with leg B taking the polarity opposite to the new leg-A selection, and both legs drive D cycles after that strobe.
- R11: With D = 0, a leg moves its drive from one gate to the other in a single edge, with no idle cycle and no overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stb_i | input | 1 | One-cycle strobe marking the start of an oscillator period |
| trip_stb_i | input | 1 | One-cycle strobe from the phase comparator |
| ilim_stb_i | input | 1 | One-cycle strobe from the current-limit comparator |
| inhibit_i | input | 1 | Level: high forces all gates low and halts the sequence |
| dead_cnt_i | input | DT_W | Dead time in clock cycles |
| a1_o | output | 1 | Leg A gate, first polarity |
| a2_o | output | 1 | Leg A gate, second polarity |
| b1_o | output | 1 | Leg B gate, first polarity |
| b2_o | output | 1 | Leg B gate, second polarity |
| pwr_active_o | output | 1 | High while the present power cycle can still be terminated |

## Verification
Each strobe is sampled at a rising edge e. Any gate that switches off does so right after edge e, and the flag changes right after that same edge. The complementary gate rises right after edge e+D, while inhibit pulls the gates low in the same cycle with no clocked delay. The bench drives inputs and compares every output at the falling edge, against a timestamp model advanced at the rising edge. That model records for each leg the edge index at which its selected gate may rise, so each result is checked in the exact cycle it is due. Separately, the bench measures the run of both-low cycles on each leg from the outputs alone and compares it with D.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_A    = 0;
  localparam int unsigned LEG_B    = 1;

  // Per-leg command produced by the period controller.
  typedef struct packed {
    logic flip;       // switching event: swap selected gate, reload dead time
    logic hold;       // sequence halted: keep reloading dead time
    logic force_en;   // while halted, overwrite the selection
    logic force_val;  // value used by force_en
  } leg_cmd_t;

endpackage

// File: rtl/psfb_leg.sv
module psfb_leg
  import psfb_pkg::*;
#(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  leg_cmd_t        cmd_i,
  input  logic [DT_W-1:0] dead_i,
  input  logic            drive_en_i,
  output logic            sel_o,
  output logic            gate_hi_o,
  output logic            gate_lo_o
);

  localparam logic [DT_W-1:0] CNT_ZERO = '0;
  localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};

  logic            sel_q, sel_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            cnt_done;
  logic            upd_en;

  assign cnt_done = (cnt_q == CNT_ZERO);

  always_comb begin
    sel_d = sel_q;
    cnt_d = cnt_q;
    if (cmd_i.flip) begin
      sel_d = ~sel_q;
      cnt_d = dead_i;
    end else if (cmd_i.hold) begin
      cnt_d = dead_i;
      if (cmd_i.force_en) begin
        sel_d = cmd_i.force_val;
      end
    end else if (!cnt_done) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  assign upd_en = cmd_i.flip | cmd_i.hold | ~cnt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= CNT_ZERO;
    end else if (upd_en) begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign sel_o     = sel_q;
  assign gate_hi_o = drive_en_i &  sel_q & cnt_done;
  assign gate_lo_o = drive_en_i & ~sel_q & cnt_done;

endmodule

// File: rtl/psfb_period_ctl.sv
module psfb_period_ctl
  import psfb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     osc_stb_i,
  input  logic     trip_stb_i,
  input  logic     ilim_stb_i,
  input  logic     inhibit_i,
  input  logic     a_sel_i,
  output leg_cmd_t a_cmd_o,
  output leg_cmd_t b_cmd_o,
  output logic     drive_en_o,
  output logic     active_o
);

  logic run_q, run_d;
  logic act_q, act_d;
  logic end_req;
  logic a_flip, b_flip, halted;
  logic st_en;

  assign end_req = trip_stb_i | ilim_stb_i;
  assign halted  = inhibit_i | ~run_q;
  assign a_flip  = osc_stb_i & ~inhibit_i;
  // leg B flips on a terminate, or at the period boundary if none came
  assign b_flip  = act_q & (end_req | osc_stb_i) & ~inhibit_i;

  always_comb begin
    a_cmd_o = '{flip: a_flip, hold: halted, force_en: 1'b0, force_val: 1'b0};
    b_cmd_o = '{flip: b_flip, hold: halted, force_en: 1'b1, force_val: a_sel_i};
  end

  always_comb begin
    run_d = run_q;
    act_d = act_q;
    if (inhibit_i) begin
      run_d = 1'b0;
      act_d = 1'b0;
    end else if (osc_stb_i) begin
      run_d = 1'b1;
      act_d = 1'b1;
    end else if (act_q && end_req) begin
      act_d = 1'b0;
    end
  end

  assign st_en = inhibit_i | osc_stb_i | (act_q & end_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= 1'b0;
    end else if (st_en) begin
      run_q <= run_d;
      act_q <= act_d;
    end
  end

  assign drive_en_o = run_q & ~inhibit_i;
  assign active_o   = act_q;

endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
  import psfb_pkg::*;
#(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_stb_i,
  input  logic            trip_stb_i,
  input  logic            ilim_stb_i,
  input  logic            inhibit_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            a1_o,
  output logic            a2_o,
  output logic            b1_o,
  output logic            b2_o,
  output logic            pwr_active_o
);

  leg_cmd_t leg_cmd  [NUM_LEGS];
  logic     leg_sel  [NUM_LEGS];
  logic     leg_hi   [NUM_LEGS];
  logic     leg_lo   [NUM_LEGS];
  leg_cmd_t a_cmd, b_cmd;
  logic     drive_en;

  psfb_period_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_stb_i  (osc_stb_i),
    .trip_stb_i (trip_stb_i),
    .ilim_stb_i (ilim_stb_i),
    .inhibit_i  (inhibit_i),
    .a_sel_i    (leg_sel[LEG_A]),
    .a_cmd_o    (a_cmd),
    .b_cmd_o    (b_cmd),
    .drive_en_o (drive_en),
    .active_o   (pwr_active_o)
  );

  assign leg_cmd[LEG_A] = a_cmd;
  assign leg_cmd[LEG_B] = b_cmd;

  for (genvar gi = 0; gi < NUM_LEGS; gi++) begin : g_leg
    psfb_leg #(.DT_W(DT_W)) u_leg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (leg_cmd[gi]),
      .dead_i     (dead_cnt_i),
      .drive_en_i (drive_en),
      .sel_o      (leg_sel[gi]),
      .gate_hi_o  (leg_hi[gi]),
      .gate_lo_o  (leg_lo[gi])
    );
  end

  // leg A: selection high drives A1; leg B: selection high drives B1
  assign a1_o = leg_hi[LEG_A];
  assign a2_o = leg_lo[LEG_A];
  assign b1_o = leg_hi[LEG_B];
  assign b2_o = leg_lo[LEG_B];

endmodule

// File: rtl/psfb_gate_seq_chk.sv
module psfb_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_stb_i,
  input logic trip_stb_i,
  input logic ilim_stb_i,
  input logic inhibit_i,
  input logic a1_o,
  input logic a2_o,
  input logic b1_o,
  input logic b2_o,
  input logic pwr_active_o
);

  a_r5_leg_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(a1_o && a2_o));

  a_r5_leg_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(b1_o && b2_o));

  a_r9_gates_low: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |-> !(a1_o || a2_o || b1_o || b2_o));

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> !pwr_active_o);

  a_r7_flag_open: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stb_i && !inhibit_i) |=> pwr_active_o);

  a_r7_flag_close: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_active_o && (trip_stb_i || ilim_stb_i) && !osc_stb_i) |=> !pwr_active_o);

  a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_active_o && !osc_stb_i) |=> !pwr_active_o);

  a_r2_a_off: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stb_i && !inhibit_i && a1_o) |=> !a1_o);

  a_r3_b_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_active_o && trip_stb_i && !inhibit_i && b1_o) |=> !b1_o);

endmodule

bind psfb_gate_seq psfb_gate_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .osc_stb_i    (osc_stb_i),
  .trip_stb_i   (trip_stb_i),
  .ilim_stb_i   (ilim_stb_i),
  .inhibit_i    (inhibit_i),
  .a1_o         (a1_o),
  .a2_o         (a2_o),
  .b1_o         (b1_o),
  .b2_o         (b2_o),
  .pwr_active_o (pwr_active_o)
);

// File: tb/psfb_gate_seq_test.sv
`timescale 1ns/1ps
module psfb_gate_seq_test;

  localparam int DT_W = 6;

  logic            clk;
  logic            rst_n;
  logic            osc, trip, ilim, inh;
  logic [DT_W-1:0] dead;
  logic            a1, a2, b1, b2, pact;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string req    = "R1";

  psfb_gate_seq #(.DT_W(DT_W)) uut (
    .clk(clk), .rst_n(rst_n), .osc_stb_i(osc), .trip_stb_i(trip),
    .ilim_stb_i(ilim), .inhibit_i(inh), .dead_cnt_i(dead),
    .a1_o(a1), .a2_o(a2), .b1_o(b1), .b2_o(b2), .pwr_active_o(pact)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // timestamp model: per leg the selected gate and the edge index it may rise at
  int edges = 0;
  bit m_run, m_act, m_asel, m_bsel;
  int m_aon, m_bon;

  always @(posedge clk) begin
    bit af, bf, halt, old_a;
    if (!rst_n) begin
      m_run = 0; m_act = 0; m_asel = 0; m_bsel = 0; m_aon = 0; m_bon = 0;
    end else begin
      af    = osc && !inh;
      bf    = m_act && (trip || ilim || osc) && !inh;
      halt  = inh || !m_run;
      old_a = m_asel;
      if (af) begin m_asel = !m_asel; m_aon = edges + int'(dead); end
      else if (halt) m_aon = edges + int'(dead);
      if (bf) begin m_bsel = !m_bsel; m_bon = edges + int'(dead); end
      else if (halt) begin m_bsel = old_a; m_bon = edges + int'(dead); end
      if (inh) begin m_run = 0; m_act = 0; end
      else if (osc) begin m_run = 1; m_act = 1; end
      else if (m_act && (trip || ilim)) m_act = 0;
    end
    edges++;
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (edge %0d)", req, what, act, exp, edges);
    end
  endtask

  // dead-time measurement from the outputs only
  bit p_hi[2], p_lo[2], gap_ok[2];
  int lowrun[2];

  task automatic measure(input int leg, input logic hi, input logic lo);
    bit fell, rose;
    fell = (p_hi[leg] && !hi) || (p_lo[leg] && !lo);
    rose = (!p_hi[leg] && hi) || (!p_lo[leg] && lo);
    if (inh) begin
      gap_ok[leg] = 0;
      lowrun[leg] = 0;
    end else begin
      if (hi && lo) chk("R5 overlap", 1'b1, 1'b0);
      if (fell && rose) begin
        if (gap_ok[leg]) begin
          checks++;
          if (dead != 0) begin
            errors++;
            $display("FAIL R11 leg %0d swap: actual gap 0 expected %0d", leg, dead);
          end
        end
        gap_ok[leg] = 1;
      end else if (rose && gap_ok[leg]) begin
        checks++;
        if (lowrun[leg] != int'(dead)) begin
          errors++;
          $display("FAIL R5 leg %0d dead time: actual %0d expected %0d", leg, lowrun[leg], dead);
        end
      end
      if (fell && !rose) begin gap_ok[leg] = 1; lowrun[leg] = 1; end
      else if (!hi && !lo) lowrun[leg]++;
      else lowrun[leg] = 0;
    end
    p_hi[leg] = hi;
    p_lo[leg] = lo;
  endtask

  task automatic compare();
    int last;
    last = edges - 1;
    chk("a1", a1, m_run && !inh &&  m_asel && last >= m_aon);
    chk("a2", a2, m_run && !inh && !m_asel && last >= m_aon);
    chk("b1", b1, m_run && !inh &&  m_bsel && last >= m_bon);
    chk("b2", b2, m_run && !inh && !m_bsel && last >= m_bon);
    chk("pwr_active", pact, m_act);
    measure(0, a1, a2);
    measure(1, b1, b2);
  endtask

  task automatic cyc(input bit c, input bit t, input bit l, input bit h);
    @(negedge clk);
    if (rst_n) compare();
    osc = c; trip = t; ilim = l; inh = h;
  endtask

  // kind 0: phase trip, 1: current limit; trip_at < 0: no terminate
  task automatic period(input int len, input int trip_at, input int kind);
    for (int i = 0; i < len; i++)
      cyc(i == 0, kind == 0 && i == trip_at, kind == 1 && i == trip_at, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; osc = 0; trip = 0; ilim = 0; inh = 0; dead = 6'd3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, strobes other than the oscillator ignored
    req = "R1";
    cyc(0, 0, 0, 0); cyc(0, 1, 0, 0); cyc(0, 0, 1, 0);
    repeat (4) cyc(0, 0, 0, 0);
    // R2, R3, R4: normal periods
    req = "R2"; period(20, 8, 0); period(20, 8, 0);
    req = "R4"; period(20, 12, 0); period(20, 5, 0);
    // R6: current-limit termination
    req = "R6"; period(20, 10, 1); period(20, 4, 1);
    // R7: long and repeated trips are locked out
    req = "R7";
    for (int i = 0; i < 22; i++)
      cyc(i == 0, (i >= 6 && i <= 12) || i == 15, i == 17, 1'b0);
    // R8: no terminate, and trip coincident with the strobe
    req = "R8"; period(20, -1, 0); period(20, -1, 0);
    period(16, 0, 0); period(16, 7, 0);
    // R11: zero dead time
    req = "R11"; dead = 6'd0; period(12, 5, 0); period(12, 3, 1); period(12, -1, 0);
    // R5: long dead time
    req = "R5"; dead = 6'd7; period(24, 10, 0); period(24, 9, 0);
    // R9: inhibit in mid period with strobes during it
    req = "R9";
    for (int i = 0; i < 20; i++)
      cyc(i == 0 || i == 10, i == 8, i == 12, i >= 4 && i < 16);
    // R10: idle after release, then restart
    req = "R10";
    repeat (6) cyc(0, 1, 0, 0);
    dead = 6'd2;
    period(18, 7, 0); period(18, 6, 0); period(18, 11, 0);
    cyc(0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule